// File: doc/BRIEF.md
# Link Health Check and Speed-Change Recovery Unit

This unit answers one question on request: is the serial link trained and usable? When a check is requested, it looks at two status bits, link-up and in-training. If the link is up and no longer training, it reports success straight away. If the link is up but still training, it re-samples a bounded number of times, with a fixed interval between samples.

If the link never settles, or was not up at all, the unit runs a stuck-transition diagnosis. It reads a receiver status register through an indirect PHY register port. It also examines the 6-bit training-state code. A clear receiver-valid flag together with state code 0x0D means the link is stuck in receiver lock while moving to the faster rate. In that case the unit pulses the receive path. It does this with a timed read-modify-write of two override bits in a second PHY register: it sets them, holds, then clears them again.

The PHY register port is a simple request/response channel served by a separate access engine. Every wait interval is a cycle count derived from the clock frequency parameter.

Top module: `lhc_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `link_up_o`, `recov_o`, `fault_o` and `phy_req_o` are all 0.
- R2: A check that finds `lnk_up_i`=1 and `lnk_training_i`=0 at its first sample ends with a one-cycle `done_o` and `link_up_o`=1, with no PHY access. `link_up_o` holds its value until the next `done_o`.
- R3: While the link is up and training, the status is re-sampled up to RETRIES (default 5) more times, each GAP_US microseconds apart. A sample showing up and not training ends the check with `link_up_o`=1 and no PHY access.
- R4: If training persists through all RETRIES+1 samples, the unit proceeds to the stuck check. Its first PHY request comes no earlier than RETRIES gap intervals after the check began.
- R5: If `lnk_up_i`=0 at the first sample, the stuck check starts at once, without any gap interval.
- R6: The stuck check is a read (`phy_we_o`=0) of address RXSTAT_ADDR (0x100D). If bit 0 of the returned data (receiver valid) is 1, the check ends with `link_up_o`=0, no recovery and no further PHY access.
- R7: If receiver valid is 0 but `ltssm_code_i` is not 0x0D, the check ends with `link_up_o`=0, no recovery and no further PHY access.
- R8: If receiver valid is 0 and `ltssm_code_i`=0x0D, recovery runs five accesses in this order: read RXSTAT_ADDR; read OVRD_ADDR (0x1005); write OVRD_ADDR with the read value OR 0x0028 (bits 5 and 3); read OVRD_ADDR again, issued at least HOLD_US microseconds after the first write completes; write OVRD_ADDR with that value AND NOT 0x0028. All other bits are preserved.
- R9: A completed recovery raises `recov_o` for exactly one cycle, together with `done_o`, and leaves `link_up_o`=0.
- R10: A PHY error response (`phy_err_i`) aborts the pass. No further request is issued. `done_o` and `fault_o` pulse together, `link_up_o`=0 and `recov_o` stays 0.
- R11: `chk_req_i` is ignored while `busy_o`=1: a busy pass produces exactly one `done_o`.
- R12: Once raised, `phy_req_o` stays high, with `phy_we_o`, `phy_addr_o` and `phy_wdata_o` stable, until a cycle in which `phy_done_i` or `phy_err_i` is 1. It then drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_req_i | input | 1 | Start a health check (taken when idle) |
| lnk_up_i | input | 1 | Link-up status from the link layer |
| lnk_training_i | input | 1 | Link training in progress |
| ltssm_code_i | input | LTSSM_W | Low bits of the training-state debug word |
| phy_req_o | output | 1 | PHY register access request |
| phy_we_o | output | 1 | 1 = write, 0 = read |
| phy_addr_o | output | PHY_AW | PHY register address |
| phy_wdata_o | output | PHY_DW | PHY write data |
| phy_rdata_i | input | PHY_DW | PHY read data, valid with `phy_done_i` |
| phy_done_i | input | 1 | Access completed |
| phy_err_i | input | 1 | Access failed |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle end-of-check strobe |
| link_up_o | output | 1 | Result of the last check |
| recov_o | output | 1 | One-cycle strobe: recovery completed |
| fault_o | output | 1 | One-cycle strobe: pass aborted by PHY error |

## Verification
The stimulus covers each status combination the decision tree separates:
- up and settled;
- up and training that clears after three intervals;
- up and training that never clears;
- link down.

These distinguish the immediate exit, the bounded retry loop and its limit, and the no-wait path into the stuck check.

The stuck check is run with several inputs:
- receiver valid set;
- a non-matching state code;
- the matching code with two different override-register seeds, which show that the write-back values preserve unrelated bits.

An error injected mid-recovery shows the abort path. A second request raised during a busy pass shows that it is ignored.

// File: rtl/lhc_pkg.sv
package lhc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_GAP,
        ST_RXV_WT,
        ST_RD1_WT,
        ST_WR1_WT,
        ST_HOLD,
        ST_RD2_WT,
        ST_WR2_WT
    } lhc_state_e;

    function automatic int unsigned lhc_us_to_cyc(int unsigned khz, int unsigned us);
        int unsigned c;
        c = (khz * us) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/lhc_wait_timer.sv
module lhc_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         fire_o
);

    typedef struct packed {
        logic         run;
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = len_i;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt <= W'(1)) begin
                tmr_d.run = 1'b0;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign fire_o = tmr_q.run && (tmr_q.cnt <= W'(1)) && !load_i;

    // R4
    tmr_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.run && !load_i && (tmr_q.cnt > W'(1)) |=> tmr_q.run);

endmodule

// File: rtl/lhc_phy_xact.sv
module lhc_phy_xact #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          req_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    input  logic          done_i,
    input  logic          err_i,
    output logic          ok_o,
    output logic          fail_o
);

    typedef struct packed {
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } xact_t;

    xact_t xa_d, xa_q;

    always_comb begin
        xa_d = xa_q;
        if (xa_q.req) begin
            if (done_i || err_i) xa_d.req = 1'b0;
        end else if (go_i) begin
            xa_d.req   = 1'b1;
            xa_d.we    = we_i;
            xa_d.addr  = addr_i;
            xa_d.wdata = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) xa_q <= '0;
        else        xa_q <= xa_d;
    end

    assign req_o   = xa_q.req;
    assign we_o    = xa_q.we;
    assign addr_o  = xa_q.addr;
    assign wdata_o = xa_q.wdata;
    assign fail_o  = xa_q.req && err_i;
    assign ok_o    = xa_q.req && done_i && !err_i;

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xa_q.req && !done_i && !err_i |=> xa_q.req && $stable(xa_q.addr)
            && $stable(xa_q.we) && $stable(xa_q.wdata));

    // R12
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xa_q.req && (done_i || err_i) |=> !xa_q.req);

    // R11
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !xa_q.req);

endmodule

// File: rtl/lhc_top.sv
module lhc_top #(
    parameter int          CLK_KHZ     = 250000,
    parameter int          GAP_US      = 1000,
    parameter int          HOLD_US     = 2000,
    parameter int          RETRIES     = 5,
    parameter int          PHY_AW      = 16,
    parameter int          PHY_DW      = 16,
    parameter int          LTSSM_W     = 6,
    parameter logic [15:0] RXSTAT_ADDR = 16'h100D,
    parameter logic [15:0] OVRD_ADDR   = 16'h1005,
    parameter logic [15:0] OVRD_MASK   = 16'h0028,
    parameter logic [5:0]  STUCK_CODE  = 6'h0D
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_req_i,
    input  logic               lnk_up_i,
    input  logic               lnk_training_i,
    input  logic [LTSSM_W-1:0] ltssm_code_i,
    output logic               phy_req_o,
    output logic               phy_we_o,
    output logic [PHY_AW-1:0]  phy_addr_o,
    output logic [PHY_DW-1:0]  phy_wdata_o,
    input  logic [PHY_DW-1:0]  phy_rdata_i,
    input  logic               phy_done_i,
    input  logic               phy_err_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               link_up_o,
    output logic               recov_o,
    output logic               fault_o
);
    import lhc_pkg::*;

    localparam int unsigned GAP_CYC  = lhc_us_to_cyc(CLK_KHZ, GAP_US);
    localparam int unsigned HOLD_CYC = lhc_us_to_cyc(CLK_KHZ, HOLD_US);
    localparam int unsigned MAX_CYC  = (GAP_CYC > HOLD_CYC) ? GAP_CYC : HOLD_CYC;
    localparam int          TW       = $clog2(MAX_CYC + 1);
    localparam int          RW       = $clog2(RETRIES + 1);
    localparam logic [PHY_AW-1:0]  A_RXSTAT = PHY_AW'(RXSTAT_ADDR);
    localparam logic [PHY_AW-1:0]  A_OVRD   = PHY_AW'(OVRD_ADDR);
    localparam logic [PHY_DW-1:0]  M_OVRD   = PHY_DW'(OVRD_MASK);
    localparam logic [LTSSM_W-1:0] C_STUCK  = LTSSM_W'(STUCK_CODE);

    typedef struct packed {
        lhc_state_e        state;
        logic [RW-1:0]     tries;
        logic              link_up;
        logic              done;
        logic              recov;
        logic              fault;
        logic              x_go;
        logic              x_we;
        logic [PHY_AW-1:0] x_addr;
        logic [PHY_DW-1:0] x_wdata;
        logic              t_load;
        logic [TW-1:0]     t_len;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic x_ok, x_fail, t_fire;

    lhc_phy_xact #(.AW(PHY_AW), .DW(PHY_DW)) u_xact (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (ctl_q.x_go),
        .we_i    (ctl_q.x_we),
        .addr_i  (ctl_q.x_addr),
        .wdata_i (ctl_q.x_wdata),
        .req_o   (phy_req_o),
        .we_o    (phy_we_o),
        .addr_o  (phy_addr_o),
        .wdata_o (phy_wdata_o),
        .done_i  (phy_done_i),
        .err_i   (phy_err_i),
        .ok_o    (x_ok),
        .fail_o  (x_fail)
    );

    lhc_wait_timer #(.W(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ctl_q.t_load),
        .len_i  (ctl_q.t_len),
        .fire_o (t_fire)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.done   = 1'b0;
        ctl_d.recov  = 1'b0;
        ctl_d.fault  = 1'b0;
        ctl_d.x_go   = 1'b0;
        ctl_d.t_load = 1'b0;

        if (x_fail) begin
            ctl_d.state   = ST_IDLE;
            ctl_d.done    = 1'b1;
            ctl_d.fault   = 1'b1;
            ctl_d.link_up = 1'b0;
        end else begin
            unique case (ctl_q.state)
                ST_IDLE: begin
                    if (chk_req_i) begin
                        ctl_d.state = ST_SAMPLE;
                        ctl_d.tries = RW'(RETRIES);
                    end
                end
                ST_SAMPLE: begin
                    if (lnk_up_i && !lnk_training_i) begin
                        ctl_d.state   = ST_IDLE;
                        ctl_d.done    = 1'b1;
                        ctl_d.link_up = 1'b1;
                    end else if (lnk_up_i && (ctl_q.tries != '0)) begin
                        ctl_d.tries  = ctl_q.tries - RW'(1);
                        ctl_d.t_load = 1'b1;
                        ctl_d.t_len  = TW'(GAP_CYC);
                        ctl_d.state  = ST_GAP;
                    end else begin
                        ctl_d.x_go   = 1'b1;
                        ctl_d.x_we   = 1'b0;
                        ctl_d.x_addr = A_RXSTAT;
                        ctl_d.state  = ST_RXV_WT;
                    end
                end
                ST_GAP: begin
                    if (t_fire) ctl_d.state = ST_SAMPLE;
                end
                ST_RXV_WT: begin
                    if (x_ok) begin
                        if (phy_rdata_i[0] || (ltssm_code_i != C_STUCK)) begin
                            ctl_d.state   = ST_IDLE;
                            ctl_d.done    = 1'b1;
                            ctl_d.link_up = 1'b0;
                        end else begin
                            ctl_d.x_go   = 1'b1;
                            ctl_d.x_we   = 1'b0;
                            ctl_d.x_addr = A_OVRD;
                            ctl_d.state  = ST_RD1_WT;
                        end
                    end
                end
                ST_RD1_WT: begin
                    if (x_ok) begin
                        ctl_d.x_go    = 1'b1;
                        ctl_d.x_we    = 1'b1;
                        ctl_d.x_addr  = A_OVRD;
                        ctl_d.x_wdata = phy_rdata_i | M_OVRD;
                        ctl_d.state   = ST_WR1_WT;
                    end
                end
                ST_WR1_WT: begin
                    if (x_ok) begin
                        ctl_d.t_load = 1'b1;
                        ctl_d.t_len  = TW'(HOLD_CYC);
                        ctl_d.state  = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (t_fire) begin
                        ctl_d.x_go   = 1'b1;
                        ctl_d.x_we   = 1'b0;
                        ctl_d.x_addr = A_OVRD;
                        ctl_d.state  = ST_RD2_WT;
                    end
                end
                ST_RD2_WT: begin
                    if (x_ok) begin
                        ctl_d.x_go    = 1'b1;
                        ctl_d.x_we    = 1'b1;
                        ctl_d.x_addr  = A_OVRD;
                        ctl_d.x_wdata = phy_rdata_i & ~M_OVRD;
                        ctl_d.state   = ST_WR2_WT;
                    end
                end
                ST_WR2_WT: begin
                    if (x_ok) begin
                        ctl_d.state   = ST_IDLE;
                        ctl_d.done    = 1'b1;
                        ctl_d.recov   = 1'b1;
                        ctl_d.link_up = 1'b0;
                    end
                end
                default: ctl_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o    = (ctl_q.state != ST_IDLE);
    assign done_o    = ctl_q.done;
    assign link_up_o = ctl_q.link_up;
    assign recov_o   = ctl_q.recov;
    assign fault_o   = ctl_q.fault;

    // R9
    recov_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recov_o |-> done_o && !link_up_o ##1 !recov_o);

    // R10
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> done_o && !recov_o && !link_up_o);

    // R10
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_err_i && phy_req_o |=> !ctl_q.x_go && !busy_o);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> link_up_o == $past(link_up_o));

    // R3
    tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.tries <= RW'(RETRIES));

    // R8
    write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_req_o && phy_we_o |-> phy_addr_o == A_OVRD);

    // R11
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: tb/sim_lhc_top.sv
module sim_lhc_top;

    localparam int CLK_KHZ = 100;
    localparam int GAP     = 100;
    localparam int HOLD    = 200;
    localparam int LAT     = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_req = 1'b0;
    logic        lnk_up = 1'b0;
    logic        lnk_trn = 1'b0;
    logic [5:0]  code = 6'h00;
    logic        phy_req, phy_we;
    logic [15:0] phy_addr, phy_wdata;
    logic [15:0] phy_rdata;
    logic        phy_done = 1'b0;
    logic        phy_err = 1'b0;
    logic        busy, done, link_up, recov, fault;

    always #2 clk = ~clk;

    lhc_top #(.CLK_KHZ(CLK_KHZ), .GAP_US(1000), .HOLD_US(2000)) u0 (
        .clk(clk), .rst_n(rst_n), .chk_req_i(chk_req),
        .lnk_up_i(lnk_up), .lnk_training_i(lnk_trn), .ltssm_code_i(code),
        .phy_req_o(phy_req), .phy_we_o(phy_we), .phy_addr_o(phy_addr),
        .phy_wdata_o(phy_wdata), .phy_rdata_i(phy_rdata),
        .phy_done_i(phy_done), .phy_err_i(phy_err),
        .busy_o(busy), .done_o(done), .link_up_o(link_up),
        .recov_o(recov), .fault_o(fault)
    );

    // PHY model
    logic        rxv = 1'b0;
    logic [15:0] ovrd_reg = 16'h0;
    logic [15:0] seed = 16'h0;
    logic        seed_go = 1'b0;
    int          err_idx = -1;
    int          acc_n = 0;
    int          lat = 0;

    assign phy_rdata = (phy_addr == 16'h100D) ? {15'h0, rxv} : ovrd_reg;

    always @(posedge clk) begin
        if (seed_go) ovrd_reg <= seed;
        if (!rst_n) begin
            phy_done <= 1'b0; phy_err <= 1'b0; lat <= 0;
        end else if (phy_done || phy_err) begin
            phy_done <= 1'b0; phy_err <= 1'b0; lat <= 0;
            acc_n <= acc_n + 1;
            if (phy_done && phy_we && phy_addr == 16'h1005) ovrd_reg <= phy_wdata;
        end else if (phy_req) begin
            if (lat == LAT) begin
                if (acc_n == err_idx) phy_err <= 1'b1;
                else                  phy_done <= 1'b1;
            end else lat <= lat + 1;
        end
    end

    // Monitor
    int          cyc = 0;
    int          n_done = 0, n_recov = 0, n_fault = 0, done_cyc = 0;
    logic        last_up = 1'b0;
    int          lg_n = 0, iss_n = 0, hold_viol = 0;
    logic [15:0] lg_addr [0:63];
    logic [15:0] lg_data [0:63];
    logic        lg_we   [0:63];
    int          lg_cyc  [0:63];
    int          iss_cyc [0:63];
    logic        p_req = 1'b0, p_resp = 1'b0, p_we = 1'b0;
    logic [15:0] p_addr = 16'h0, p_wd = 16'h0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (done) begin
            n_done <= n_done + 1; last_up <= link_up; done_cyc <= cyc;
        end
        if (recov) n_recov <= n_recov + 1;
        if (fault) n_fault <= n_fault + 1;
        if (phy_req && !p_req && iss_n < 64) begin
            iss_cyc[iss_n] <= cyc; iss_n <= iss_n + 1;
        end
        if (phy_req && (phy_done || phy_err) && lg_n < 64) begin
            lg_addr[lg_n] <= phy_addr;
            lg_we[lg_n]   <= phy_we;
            lg_data[lg_n] <= phy_we ? phy_wdata : phy_rdata;
            lg_cyc[lg_n]  <= cyc;
            lg_n <= lg_n + 1;
        end
        if (p_req && !p_resp && (!phy_req || phy_addr != p_addr || phy_we != p_we || phy_wdata != p_wd))
            hold_viol <= hold_viol + 1;
        p_req <= phy_req; p_resp <= phy_done || phy_err;
        p_addr <= phy_addr; p_we <= phy_we; p_wd <= phy_wdata;
    end

    int n_chk = 0, n_bad = 0;
    logic fin = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!fin) begin
            fin = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    task automatic pulse_req();
        @(negedge clk) chk_req = 1'b1;
        @(negedge clk) chk_req = 1'b0;
    endtask

    task automatic wait_done(input int base, input string req);
        int k;
        k = 0;
        while (n_done == base && k < 3000) begin @(negedge clk); k++; end
        check(n_done == base + 1, req, n_done - base, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic load_seed(input logic [15:0] v);
        @(negedge clk) begin seed = v; seed_go = 1'b1; end
        @(negedge clk) seed_go = 1'b0;
    endtask

    task automatic t_reset();
        check(!busy && !done && !link_up && !recov && !fault && !phy_req, "R1",
              {busy, done, link_up, recov, fault, phy_req}, 0);
    endtask

    task automatic t_up_now();
        int b, l;
        lnk_up = 1; lnk_trn = 0; b = n_done; l = lg_n;
        pulse_req(); wait_done(b, "R2");
        check(last_up == 1'b1, "R2", last_up, 1);
        check(lg_n == l, "R2", lg_n - l, 0);
        repeat (20) @(negedge clk);
        check(link_up == 1'b1, "R2", link_up, 1);
    endtask

    task automatic t_train_clears();
        int b, l, s;
        lnk_up = 1; lnk_trn = 1; b = n_done; l = lg_n;
        pulse_req(); s = cyc;
        repeat (250) @(negedge clk);
        lnk_trn = 0;
        wait_done(b, "R3");
        check(last_up == 1'b1, "R3", last_up, 1);
        check(lg_n == l, "R3", lg_n - l, 0);
        check(done_cyc - s >= 3 * GAP && done_cyc - s <= 3 * GAP + 20, "R3", done_cyc - s, 3 * GAP);
    endtask

    task automatic t_train_stuck();
        int b, l, i, s;
        lnk_up = 1; lnk_trn = 1; rxv = 1; code = 6'h0D; b = n_done; l = lg_n; i = iss_n;
        pulse_req(); s = cyc;
        wait_done(b, "R4");
        check(iss_cyc[i] - s >= 5 * GAP && iss_cyc[i] - s < 5 * GAP + 20, "R4", iss_cyc[i] - s, 5 * GAP);
        check(lg_n - l == 1 && lg_addr[l] == 16'h100D && !lg_we[l], "R6", lg_addr[l], 16'h100D);
        check(last_up == 1'b0 && n_recov == 0, "R6", last_up, 0);
    endtask

    task automatic t_down_rxv();
        int b, l, i, s;
        lnk_up = 0; lnk_trn = 0; rxv = 1; code = 6'h0D; b = n_done; l = lg_n; i = iss_n;
        pulse_req(); s = cyc;
        wait_done(b, "R5");
        check(iss_cyc[i] - s < 10, "R5", iss_cyc[i] - s, 2);
        check(lg_n - l == 1, "R6", lg_n - l, 1);
        check(last_up == 1'b0, "R6", last_up, 0);
    endtask

    task automatic t_other_code();
        int b, l, r;
        lnk_up = 0; rxv = 0; code = 6'h11; b = n_done; l = lg_n; r = n_recov;
        pulse_req(); wait_done(b, "R7");
        check(lg_n - l == 1 && lg_addr[l] == 16'h100D, "R7", lg_n - l, 1);
        check(n_recov == r && last_up == 1'b0, "R7", n_recov - r, 0);
    endtask

    task automatic t_recover(input logic [15:0] sd);
        int b, l, r;
        logic [15:0] w1, w2;
        w1 = sd | 16'h0028; w2 = w1 & ~16'h0028;
        load_seed(sd);
        lnk_up = 0; rxv = 0; code = 6'h0D; b = n_done; l = lg_n; r = n_recov;
        pulse_req(); wait_done(b, "R8");
        check(lg_n - l == 5, "R8", lg_n - l, 5);
        check(lg_addr[l+1] == 16'h1005 && !lg_we[l+1] && lg_data[l+1] == sd, "R8", lg_data[l+1], sd);
        check(lg_we[l+2] && lg_addr[l+2] == 16'h1005 && lg_data[l+2] == w1, "R8", lg_data[l+2], w1);
        check(!lg_we[l+3] && lg_cyc[l+3] - lg_cyc[l+2] >= HOLD, "R8", lg_cyc[l+3] - lg_cyc[l+2], HOLD);
        check(lg_we[l+4] && lg_data[l+4] == w2, "R8", lg_data[l+4], w2);
        check(n_recov == r + 1 && last_up == 1'b0, "R9", n_recov - r, 1);
    endtask

    task automatic t_error();
        int b, l, r, f;
        load_seed(16'h0F00);
        lnk_up = 0; rxv = 0; code = 6'h0D; b = n_done; l = lg_n; r = n_recov; f = n_fault;
        err_idx = acc_n + 2;
        pulse_req(); wait_done(b, "R10");
        repeat (HOLD + 20) @(negedge clk);
        check(lg_n - l == 3, "R10", lg_n - l, 3);
        check(n_fault == f + 1 && n_recov == r, "R10", n_fault - f, 1);
        check(last_up == 1'b0 && !busy, "R10", busy, 0);
        err_idx = -1;
    endtask

    task automatic t_busy_ignore();
        int b, l;
        load_seed(16'h0001);
        lnk_up = 0; rxv = 0; code = 6'h0D; b = n_done; l = lg_n;
        pulse_req();
        repeat (40) @(negedge clk);
        pulse_req();
        wait_done(b, "R11");
        repeat (HOLD + 50) @(negedge clk);
        check(n_done == b + 1, "R11", n_done - b, 1);
        check(lg_n - l == 5, "R11", lg_n - l, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_up_now();
        t_train_clears();
        t_train_stuck();
        t_down_rxv();
        t_other_code();
        t_recover(16'hA5C2);
        t_recover(16'hFFFF);
        t_error();
        t_busy_ignore();
        check(hold_viol == 0, "R12", hold_viol, 0);
        finish_run();
    end

endmodule